// File: doc/BRIEF.md
# Local Interrupt Acceptance and Priority Unit

This unit sits beside one processor core and takes in interrupt messages arriving from the system. It first checks whether each message is addressed to this core. Ordinary (fixed-class) messages are then recorded in a pending vector, which has one bit per vector number. The unit presents the most urgent pending vector to the core only when that vector outranks what the core is already doing. The core's current rank is the larger of a software-written task priority and the class of the most urgent vector already in service.

When the core acknowledges, the offered vector moves from pending to in-service. A higher-class vector can still be offered and nested on top of a lower-class one. An end-of-service write retires the most urgent in-service vector. If that vector arrived level-triggered, the unit emits a one-cycle end-of-service notice carrying the vector, so the originating source can re-arm. Messages of the system-management, non-maskable, init, startup and external-controller kinds skip all of this bookkeeping. They go to the core on a separate direct line.

Top module: `lirq_accept_top`

## Requirements
- R1: After synchronous reset the pending, in-service and trigger-kind vectors are all clear, the local ID and task priority are 0, and `irq_req`, `direct_valid` and `eoi_bcast_valid` are low.
- R2: An accepted message of delivery kind 3'b000 (fixed) or 3'b001 (lowest-priority, handled as fixed) sets the pending bit of its vector on the clock edge where `msg_valid` is sampled. Without a message or an acknowledge the pending vector does not change.
- R3: A message is accepted only when `msg_logical` is 0 and `msg_dest` equals the local ID. Logical-mode messages, messages with a different destination, and the reserved delivery kind 3'b011 leave every output and all state unchanged.
- R4: The class of a vector is its upper nibble (bits 7:4). The processor priority is the task priority when its class is at least the class of the highest in-service vector. Otherwise it is that in-service class with a zero low nibble.
- R5: `irq_req` is high, with `irq_vector` holding the highest pending vector, exactly when that vector's class is strictly greater than the processor priority's class. A lower or equal class waits.
- R6: `core_ack` while `irq_req` is high clears the offered vector's pending bit and sets its in-service bit on that edge. `core_ack` while `irq_req` is low has no effect.
- R7: `eoi_wr` clears the highest set in-service bit. If that vector was accepted with `msg_level` = 1, `eoi_bcast_valid` pulses for one cycle after the edge, with `eoi_bcast_vector` equal to the vector. An edge-triggered vector, or an empty in-service vector, produces no pulse.
- R8: Accepted messages of kinds 3'b010 (management), 3'b100 (non-maskable), 3'b101 (init), 3'b110 (startup) and 3'b111 (external controller) raise `direct_valid` for the one cycle after the edge, with `direct_mode` and `direct_vector` copied from the message. The pending vector is not touched.
- R9: A pending vector whose class beats the in-service class is offered and can be acknowledged while a lower-class vector is still in service, so several in-service bits may be set at once.
- R10: Writes through `id_wr` and `tpr_wr` take effect on the edge where they are sampled. Acceptance and offering use the new values from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Incoming message strobe |
| msg_vector | input | 8 | Message vector number |
| msg_mode | input | 3 | Delivery kind |
| msg_logical | input | 1 | Destination mode, 1 = logical (not accepted) |
| msg_dest | input | 8 | Destination field |
| msg_level | input | 1 | Trigger kind, 1 = level |
| id_wr | input | 1 | Local ID write strobe |
| id_wdata | input | 8 | Local ID write value |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority write value |
| eoi_wr | input | 1 | End-of-service write strobe |
| core_ack | input | 1 | Core takes the offered vector |
| irq_req | output | 1 | Vector offered to the core |
| irq_vector | output | 8 | Offered vector |
| direct_valid | output | 1 | One-cycle direct delivery pulse |
| direct_mode | output | 3 | Delivery kind of the direct message |
| direct_vector | output | 8 | Vector of the direct message |
| eoi_bcast_valid | output | 1 | One-cycle end-of-service notice for a level vector |
| eoi_bcast_vector | output | 8 | Retired level vector |

## Verification
Every state change lands on the clock edge that samples the input. The offer (`irq_req`, `irq_vector`) is decoded directly from registered state, so it reflects a message, acknowledge, end-of-service or task-priority write immediately after that same edge. `direct_valid` and `eoi_bcast_valid` are registered pulses that are high only for the cycle following the edge. The bench drives inputs on the falling edge, then samples 2 ns after the next rising edge and withdraws the strobe there. This way each result is read in the single cycle it is due, and no pulse is read a cycle late.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

    localparam int VEC_W   = 8;
    localparam int NUM_VEC = 1 << VEC_W;
    localparam int CLS_W   = 4;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'b000,
        DM_LOWPRI = 3'b001,
        DM_SMI    = 3'b010,
        DM_RSVD   = 3'b011,
        DM_NMI    = 3'b100,
        DM_INIT   = 3'b101,
        DM_START  = 3'b110,
        DM_EXTINT = 3'b111
    } dmode_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vector;
        dmode_e           mode;
        logic             logical;
        logic [VEC_W-1:0] dest;
        logic             level;
    } irq_msg_t;

    typedef struct packed {
        logic             any;
        logic [VEC_W-1:0] idx;
    } top_bit_t;

    // Index of the highest set bit; ascending scan so the last hit wins.
    function automatic top_bit_t find_top(input logic [NUM_VEC-1:0] v);
        top_bit_t r;
        r.any = 1'b0;
        r.idx = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (v[i]) begin
                r.any = 1'b1;
                r.idx = VEC_W'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [CLS_W-1:0] cls_of(input logic [VEC_W-1:0] v);
        return v[VEC_W-1 -: CLS_W];
    endfunction

endpackage

// File: rtl/lirq_dest_filter.sv
module lirq_dest_filter
    import lirq_pkg::*;
(
    input  irq_msg_t         msg,
    input  logic [VEC_W-1:0] local_id,
    output logic             take_fixed,
    output logic             take_direct
);
    logic hit;

    always_comb begin
        hit         = msg.valid && !msg.logical && (msg.dest == local_id);
        take_fixed  = 1'b0;
        take_direct = 1'b0;
        unique case (msg.mode)
            DM_FIXED, DM_LOWPRI:                        take_fixed  = hit;
            DM_SMI, DM_NMI, DM_INIT, DM_START, DM_EXTINT: take_direct = hit;
            default: ;
        endcase
    end
endmodule

// File: rtl/lirq_vec_regs.sv
module lirq_vec_regs
    import lirq_pkg::*;
#(
    parameter int N = NUM_VEC,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [IW-1:0] set_vec,
    input  logic          set_level,
    input  logic          ack_en,
    input  logic [IW-1:0] ack_vec,
    input  logic          eoi_en,
    input  logic [IW-1:0] eoi_vec,
    output logic [N-1:0]  irr,
    output logic [N-1:0]  isr,
    output logic [N-1:0]  tmr
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic hit_set, hit_ack, hit_eoi;
        assign hit_set = set_en && (set_vec == IW'(g));
        assign hit_ack = ack_en && (ack_vec == IW'(g));
        assign hit_eoi = eoi_en && (eoi_vec == IW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                irr[g] <= 1'b0;
                isr[g] <= 1'b0;
                tmr[g] <= 1'b0;
            end else begin
                if (hit_ack) irr[g] <= 1'b0;
                if (hit_set) irr[g] <= 1'b1;
                if (hit_eoi) isr[g] <= 1'b0;
                if (hit_ack) isr[g] <= 1'b1;
                if (hit_set) tmr[g] <= set_level;
            end
        end
    end
endmodule

// File: rtl/lirq_prio.sv
module lirq_prio
    import lirq_pkg::*;
(
    input  logic [NUM_VEC-1:0] irr,
    input  logic [NUM_VEC-1:0] isr,
    input  logic [VEC_W-1:0]   tpr,
    output logic               offer,
    output logic [VEC_W-1:0]   offer_vec,
    output top_bit_t           svc_top,
    output logic [VEC_W-1:0]   ppr
);
    top_bit_t req_top;

    always_comb begin
        req_top = find_top(irr);
        svc_top = find_top(isr);
        if (!svc_top.any || cls_of(tpr) >= cls_of(svc_top.idx))
            ppr = tpr;
        else
            ppr = {cls_of(svc_top.idx), {(VEC_W-CLS_W){1'b0}}};
        offer     = req_top.any && (cls_of(req_top.idx) > cls_of(ppr));
        offer_vec = req_top.idx;
    end
endmodule

// File: rtl/lirq_accept_top.sv
module lirq_accept_top
    import lirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             msg_valid,
    input  logic [VEC_W-1:0] msg_vector,
    input  logic [2:0]       msg_mode,
    input  logic             msg_logical,
    input  logic [VEC_W-1:0] msg_dest,
    input  logic             msg_level,
    input  logic             id_wr,
    input  logic [VEC_W-1:0] id_wdata,
    input  logic             tpr_wr,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             eoi_wr,
    input  logic             core_ack,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vector,
    output logic             direct_valid,
    output logic [2:0]       direct_mode,
    output logic [VEC_W-1:0] direct_vector,
    output logic             eoi_bcast_valid,
    output logic [VEC_W-1:0] eoi_bcast_vector
);
    irq_msg_t             msg;
    logic                 take_fixed, take_direct;
    logic [VEC_W-1:0]     id_q, tpr_q, ppr;
    logic [NUM_VEC-1:0]   irr_q, isr_q, tmr_q;
    top_bit_t             svc_top;
    logic                 ack_en, eoi_en;

    always_comb begin
        msg.valid   = msg_valid;
        msg.vector  = msg_vector;
        msg.mode    = dmode_e'(msg_mode);
        msg.logical = msg_logical;
        msg.dest    = msg_dest;
        msg.level   = msg_level;
    end

    lirq_dest_filter u_filt (
        .msg         (msg),
        .local_id    (id_q),
        .take_fixed  (take_fixed),
        .take_direct (take_direct)
    );

    assign ack_en = core_ack && irq_req;
    assign eoi_en = eoi_wr && svc_top.any;

    lirq_vec_regs #(.N(NUM_VEC)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .set_en    (take_fixed),
        .set_vec   (msg.vector),
        .set_level (msg.level),
        .ack_en    (ack_en),
        .ack_vec   (irq_vector),
        .eoi_en    (eoi_en),
        .eoi_vec   (svc_top.idx),
        .irr       (irr_q),
        .isr       (isr_q),
        .tmr       (tmr_q)
    );

    lirq_prio u_prio (
        .irr       (irr_q),
        .isr       (isr_q),
        .tpr       (tpr_q),
        .offer     (irq_req),
        .offer_vec (irq_vector),
        .svc_top   (svc_top),
        .ppr       (ppr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q             <= '0;
            tpr_q            <= '0;
            direct_valid     <= 1'b0;
            direct_mode      <= '0;
            direct_vector    <= '0;
            eoi_bcast_valid  <= 1'b0;
            eoi_bcast_vector <= '0;
        end else begin
            if (id_wr)  id_q  <= id_wdata;
            if (tpr_wr) tpr_q <= tpr_wdata;
            direct_valid <= take_direct;
            if (take_direct) begin
                direct_mode   <= msg_mode;
                direct_vector <= msg_vector;
            end
            eoi_bcast_valid <= eoi_en && tmr_q[svc_top.idx];
            if (eoi_en) eoi_bcast_vector <= svc_top.idx;
        end
    end
endmodule

// File: rtl/lirq_accept_chk.sv
module lirq_accept_chk
    import lirq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               msg_valid,
    input logic               core_ack,
    input logic               eoi_wr,
    input logic               irq_req,
    input logic [VEC_W-1:0]   irq_vector,
    input logic [VEC_W-1:0]   tpr_q,
    input logic [NUM_VEC-1:0] irr_q,
    input logic [NUM_VEC-1:0] isr_q,
    input logic               direct_valid,
    input logic               eoi_bcast_valid,
    input logic [VEC_W-1:0]   eoi_bcast_vector
);
    p_quiet_pending_r2: assert property (@(posedge clk) disable iff (rst)
        (!msg_valid && !core_ack) |=> $stable(irr_q));

    p_offer_is_pending_r5: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> irr_q[irq_vector]);

    p_offer_beats_tpr_r5: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vector[VEC_W-1 -: CLS_W] > tpr_q[VEC_W-1 -: CLS_W]));

    p_ack_moves_r6: assert property (@(posedge clk) disable iff (rst)
        (core_ack && irq_req) |=> isr_q[$past(irq_vector)]);

    p_bcast_cause_r7: assert property (@(posedge clk) disable iff (rst)
        eoi_bcast_valid |-> ($past(eoi_wr) && !isr_q[eoi_bcast_vector]));

    p_direct_cause_r8: assert property (@(posedge clk) disable iff (rst)
        direct_valid |-> $past(msg_valid));
endmodule

bind lirq_accept_top lirq_accept_chk chk_i (
    .clk              (clk),
    .rst              (rst),
    .msg_valid        (msg_valid),
    .core_ack         (core_ack),
    .eoi_wr           (eoi_wr),
    .irq_req          (irq_req),
    .irq_vector       (irq_vector),
    .tpr_q            (tpr_q),
    .irr_q            (irr_q),
    .isr_q            (isr_q),
    .direct_valid     (direct_valid),
    .eoi_bcast_valid  (eoi_bcast_valid),
    .eoi_bcast_vector (eoi_bcast_vector)
);

// File: tb/lirq_accept_top_tb_top.sv
`timescale 1ns/1ps
module lirq_accept_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       msg_valid = 0, msg_logical = 0, msg_level = 0;
    logic [7:0] msg_vector = 0, msg_dest = 0;
    logic [2:0] msg_mode = 0;
    logic       id_wr = 0, tpr_wr = 0, eoi_wr = 0, core_ack = 0;
    logic [7:0] id_wdata = 0, tpr_wdata = 0;
    logic       irq_req, direct_valid, eoi_bcast_valid;
    logic [7:0] irq_vector, direct_vector, eoi_bcast_vector;
    logic [2:0] direct_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    lirq_accept_top dut_i (.*);

    // {mode, logical, dest, level, vector, exp_req, exp_vec, exp_direct}
    localparam int TN = 7;
    localparam logic [30:0] TBL [TN] = '{
        {3'b000, 1'b0, 8'd5, 1'b0, 8'h31, 1'b1, 8'h31, 1'b0},
        {3'b000, 1'b0, 8'd6, 1'b0, 8'h80, 1'b1, 8'h31, 1'b0},
        {3'b000, 1'b1, 8'd5, 1'b0, 8'h90, 1'b1, 8'h31, 1'b0},
        {3'b001, 1'b0, 8'd5, 1'b0, 8'h45, 1'b1, 8'h45, 1'b0},
        {3'b100, 1'b0, 8'd5, 1'b0, 8'h02, 1'b1, 8'h45, 1'b1},
        {3'b011, 1'b0, 8'd5, 1'b0, 8'hA0, 1'b1, 8'h45, 1'b0},
        {3'b000, 1'b0, 8'd5, 1'b1, 8'h20, 1'b1, 8'h45, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic edge_sample();
        @(posedge clk);
        #2;
    endtask

    task automatic send(input logic [2:0] m, input logic lg, input logic [7:0] d,
                        input logic lv, input logic [7:0] v);
        @(negedge clk);
        msg_valid = 1; msg_mode = m; msg_logical = lg; msg_dest = d;
        msg_level = lv; msg_vector = v;
        edge_sample();
        msg_valid = 0;
    endtask

    task automatic wr_tpr(input logic [7:0] v);
        @(negedge clk); tpr_wr = 1; tpr_wdata = v;
        edge_sample(); tpr_wr = 0;
    endtask

    task automatic wr_id(input logic [7:0] v);
        @(negedge clk); id_wr = 1; id_wdata = v;
        edge_sample(); id_wr = 0;
    endtask

    task automatic ack();
        @(negedge clk); core_ack = 1;
        edge_sample(); core_ack = 0;
    endtask

    task automatic eoi();
        @(negedge clk); eoi_wr = 1;
        edge_sample(); eoi_wr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk("R1 irq_req", irq_req, 0);
        chk("R1 direct_valid", direct_valid, 0);
        chk("R1 eoi_bcast_valid", eoi_bcast_valid, 0);
        @(negedge clk); rst = 0;

        wr_id(8'd5);                       // R10

        for (int i = 0; i < TN; i++) begin
            send(TBL[i][30:28], TBL[i][27], TBL[i][26:19], TBL[i][18], TBL[i][17:10]);
            chk($sformatf("R2/R3 table %0d irq_req", i), irq_req, TBL[i][9]);
            chk($sformatf("R5 table %0d irq_vector", i), irq_vector, TBL[i][8:1]);
            chk($sformatf("R8 table %0d direct_valid", i), direct_valid, TBL[i][0]);
            if (TBL[i][0]) begin
                chk("R8 direct_mode", direct_mode, TBL[i][30:28]);
                chk("R8 direct_vector", direct_vector, TBL[i][17:10]);
            end
        end
        // pending now 0x45, 0x31, 0x20(level)

        // R5/R10: strict comparison against task priority
        wr_tpr(8'h50); chk("R10 tpr above blocks", irq_req, 0);
        wr_tpr(8'h40); chk("R5 equal class waits", irq_req, 0);
        wr_tpr(8'h30); chk("R5 higher class offered", irq_req, 1);
        chk("R5 vector", irq_vector, 8'h45);

        // R6/R4: acknowledge raises in-service class to 4
        ack(); chk("R4 in-service class masks 0x31", irq_req, 0);

        // R9: nested higher class
        send(3'b000, 1'b0, 8'd5, 1'b0, 8'h61);
        chk("R9 nested offer", irq_req, 1);
        chk("R9 nested vector", irq_vector, 8'h61);
        ack(); chk("R9 after nested ack", irq_req, 0);

        // R6: acknowledge with nothing offered is ignored
        ack(); chk("R6 stray ack", irq_req, 0);

        // R7: retire 0x61 (edge), then 0x45 (edge)
        eoi(); chk("R7 edge no bcast", eoi_bcast_valid, 0);
        chk("R7 still masked by 0x45", irq_req, 0);
        eoi(); chk("R7 second edge no bcast", eoi_bcast_valid, 0);
        chk("R5 0x31 waits on tpr 0x30", irq_req, 0);
        wr_tpr(8'h10); chk("R10 tpr lowered", irq_vector, 8'h31);
        chk("R10 tpr lowered req", irq_req, 1);

        ack(); chk("R4 0x20 below class 3", irq_req, 0);
        eoi(); chk("R7 retire 0x31 no bcast", eoi_bcast_valid, 0);
        chk("R5 0x20 offered", irq_vector, 8'h20);
        chk("R5 0x20 req", irq_req, 1);
        ack();
        eoi(); chk("R7 level bcast", eoi_bcast_valid, 1);
        chk("R7 level bcast vector", eoi_bcast_vector, 8'h20);
        edge_sample(); chk("R7 bcast one cycle", eoi_bcast_valid, 0);
        eoi(); chk("R7 empty in-service no bcast", eoi_bcast_valid, 0);

        // R3/R10: new local ID
        wr_id(8'd9);
        send(3'b000, 1'b0, 8'd5, 1'b0, 8'h70);
        chk("R3 old id ignored", irq_req, 0);
        send(3'b010, 1'b0, 8'd5, 1'b0, 8'h03);
        chk("R3 direct to old id ignored", direct_valid, 0);
        send(3'b000, 1'b0, 8'd9, 1'b0, 8'h70);
        chk("R3 new id accepted", irq_vector, 8'h70);
        chk("R3 new id req", irq_req, 1);

        // R1: reset clears pending
        @(negedge clk); rst = 1;
        edge_sample();
        chk("R1 reset clears pending", irq_req, 0);
        @(negedge clk); rst = 0;

        finish_run();
    end
endmodule